// File: doc/BRIEF.md
# Load-Based Phase Count Manager

This block decides how many phases of a multiphase buck rail switch, and whether the rail runs in continuous (CCM) or discontinuous (DCM) conduction. It does not measure current and does not make PWM. It takes a load current code, the power-state command and a strap that turns automatic power management on or off. It drives a contiguous phase-enable mask and a DCM flag to the modulator.

After reset the block runs a detection window. A phase whose current-sense input is seen pulled to the supply at any clock edge in that window counts as unpopulated. Populated phases must be contiguous from phase 1, and phase 1 is always present.

Once the window closes, the load code is mapped to one of four load levels: DCM, one phase, two phases, or all phases. The power state and the strap then decide how that level is used. Phases are added at once when the load rises. They are shed only after the load has stayed below a lowered threshold for a dwell time.

Top module: `phase_mgr`

## Requirements
- R1: After rst_ni is released, det_done_o goes high on exactly the DET_CYC-th rising clock edge and stays high until the next reset. While det_done_o is low, en_mask_o is all zero and dcm_o is low.
- R2: A sense input found high at any edge inside the window marks its phase unpopulated. pop_cnt_o is 1 plus the number of consecutive low inputs counted upward from phase 2 (bit 1). The bit 0 input is ignored, and so are all sense inputs after the window.
- R3: pstate_i encodes 0 = PS0, 1 = PS1, 2 = PS2, 3 = PS3. In PS0 with auto_en_i low, all populated phases run in CCM.
- R4: In PS0 with auto_en_i high, the load level maps to the outputs as follows:
  - DCM gives one phase with dcm_o high.
  - One-phase gives one phase in CCM.
  - Two-phase gives min(2, pop_cnt_o) phases.
  - All gives pop_cnt_o phases.
  
  A rising load picks the level from the code: below TH_DCM (5) is DCM, below TH_ONE (15) is one phase, below TH_TWO (25) is two phases, and 25 or more is all phases. A rise takes effect at the next clock edge. The load code is unsigned, with 1 A per LSB.
- R5: A lower level is chosen only when the load is below the corresponding threshold minus HYS. With HYS = 2 those bounds are 3, 13 and 23. A load at or above the lowered bound holds the current level indefinitely.
- R6: A drop takes effect on the DWELL-th consecutive clock edge at which the load is below the current level's lowered bound. The level goes straight to the lowest level the load allows. Any edge without that condition restarts the count. The level is tracked in every power state and resets to all-phases.
- R7: In PS1, exactly one phase runs in CCM, whatever the load and the strap.
- R8: In PS2 and PS3, exactly one phase runs. dcm_o is high exactly when the tracked level is DCM, whatever the strap.
- R9: en_mask_o bit k enables phase k+1. The mask is always contiguous from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, starts detection |
| sense_hi_i | input | NPH | Per-phase flag: sense input pulled to supply |
| auto_en_i | input | 1 | Strap: automatic power management enable |
| pstate_i | input | 2 | Power-state command, 0..3 = PS0..PS3 |
| load_i | input | IW | Load current code, 1 A per LSB |
| det_done_o | output | 1 | Detection window closed |
| pop_cnt_o | output | clog2(NPH+1) | Populated phase count |
| en_mask_o | output | NPH | Phase enable mask, bit 0 = phase 1 |
| dcm_o | output | 1 | Discontinuous conduction selected |

## Verification
The bench builds the block with NPH = 4, DET_CYC = 20, DWELL = 8 and HYS = 2, keeping the default thresholds. At that size every one of the 16 sense patterns can be run through detection. The dwell expiry and its restart fall within a few cycles, so they can be checked directly. Populated counts of 1, 2 and 4 let the two-phase cap and the full mask each be observed. A load script with ramps, holds and interruptions is replayed in all four power states with the strap both ways. Every cycle is compared with an arithmetic model of the levels.

// File: rtl/phase_mgr_pkg.sv
package phase_mgr_pkg;
  typedef enum logic [1:0] {
    LVL_DCM = 2'd0,
    LVL_ONE = 2'd1,
    LVL_TWO = 2'd2,
    LVL_ALL = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    PS0 = 2'd0,
    PS1 = 2'd1,
    PS2 = 2'd2,
    PS3 = 2'd3
  } pstate_e;
endpackage

// File: rtl/phase_detect.sv
module phase_detect #(
  parameter int NPH     = 8,
  parameter int DET_CYC = 150000,
  parameter int CW      = $clog2(NPH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] sense_hi_i,
  output logic           done_o,
  output logic [CW-1:0]  pop_o
);
  localparam int TW = $clog2(DET_CYC + 1);

  logic [TW-1:0]  tmr_q;
  logic [NPH-1:0] seen_q;
  logic [NPH-1:0] run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      seen_q <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      seen_q <= seen_q | sense_hi_i;
      if (tmr_q == TW'(DET_CYC - 1)) done_o <= 1'b1;
      else                           tmr_q  <= tmr_q + 1'b1;
    end
  end

  // phase 1 always present; chain breaks at the first pulled-high phase
  assign run[0] = 1'b1;
  for (genvar g = 1; g < NPH; g++) begin : g_run
    assign run[g] = run[g-1] & ~seen_q[g];
  end

  always_comb begin
    pop_o = '0;
    for (int k = 0; k < NPH; k++) pop_o = pop_o + CW'(run[k]);
  end

  assert_done_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_pop_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(pop_o));
  assert_pop_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o >= CW'(1)) && (pop_o <= CW'(NPH)));
endmodule

// File: rtl/load_level.sv
module load_level
  import phase_mgr_pkg::*;
#(
  parameter int IW     = 9,
  parameter int TH_DCM = 5,
  parameter int TH_ONE = 15,
  parameter int TH_TWO = 25,
  parameter int HYS    = 2,
  parameter int DWELL  = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] load_i,
  output lvl_e          lvl_o
);
  localparam int DW = $clog2(DWELL + 1);
  localparam logic [IW-1:0] UP0 = IW'(TH_DCM);
  localparam logic [IW-1:0] UP1 = IW'(TH_ONE);
  localparam logic [IW-1:0] UP2 = IW'(TH_TWO);
  localparam logic [IW-1:0] DN0 = IW'(TH_DCM - HYS);
  localparam logic [IW-1:0] DN1 = IW'(TH_ONE - HYS);
  localparam logic [IW-1:0] DN2 = IW'(TH_TWO - HYS);

  lvl_e          up_lvl, dn_lvl;
  logic [DW-1:0] cnt_q;

  always_comb begin
    if      (load_i >= UP2) up_lvl = LVL_ALL;
    else if (load_i >= UP1) up_lvl = LVL_TWO;
    else if (load_i >= UP0) up_lvl = LVL_ONE;
    else                    up_lvl = LVL_DCM;
    if      (load_i >= DN2) dn_lvl = LVL_ALL;
    else if (load_i >= DN1) dn_lvl = LVL_TWO;
    else if (load_i >= DN0) dn_lvl = LVL_ONE;
    else                    dn_lvl = LVL_DCM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= LVL_ALL;
      cnt_q <= '0;
    end else if (up_lvl > lvl_o) begin
      lvl_o <= up_lvl;
      cnt_q <= '0;
    end else if (dn_lvl < lvl_o) begin
      if (cnt_q == DW'(DWELL - 1)) begin
        lvl_o <= dn_lvl;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assert_rise_next_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_lvl > lvl_o) |=> (lvl_o == $past(up_lvl)));
  assert_drop_needs_dwell_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != DW'(DWELL - 1)) |=> (lvl_o >= $past(lvl_o)));
  assert_hold_in_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((up_lvl <= lvl_o) && (dn_lvl >= lvl_o)) |=> (lvl_o == $past(lvl_o)));
endmodule

// File: rtl/phase_mask_dec.sv
module phase_mask_dec
  import phase_mgr_pkg::*;
#(
  parameter int NPH = 8,
  parameter int CW  = $clog2(NPH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           done_i,
  input  logic [CW-1:0]  pop_i,
  input  lvl_e           lvl_i,
  input  logic [1:0]     pstate_i,
  input  logic           auto_en_i,
  output logic [NPH-1:0] mask_o,
  output logic           dcm_o
);
  logic [CW-1:0] nact;
  pstate_e       ps;

  assign ps = pstate_e'(pstate_i);

  always_comb begin
    nact  = '0;
    dcm_o = 1'b0;
    if (done_i) begin
      unique case (ps)
        PS0: begin
          if (!auto_en_i) nact = pop_i;
          else begin
            unique case (lvl_i)
              LVL_DCM: begin nact = CW'(1); dcm_o = 1'b1; end
              LVL_ONE: nact = CW'(1);
              LVL_TWO: nact = (pop_i < CW'(2)) ? pop_i : CW'(2);
              default: nact = pop_i;
            endcase
          end
        end
        PS1: nact = CW'(1);
        default: begin
          nact  = CW'(1);
          dcm_o = (lvl_i == LVL_DCM);
        end
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_mask
    assign mask_o[g] = (CW'(g) < nact);
  end

  assert_mask_contig_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((({1'b0, mask_o} + 1'b1) & {1'b0, mask_o}) == '0));
  assert_mask_within_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mask_o) <= int'(pop_i)));
  assert_dcm_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcm_o |-> (mask_o == NPH'(1)));
  assert_ps1_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ps == PS1) |-> ($countones(mask_o) == 1 && !dcm_o));
endmodule

// File: rtl/phase_mgr.sv
module phase_mgr
  import phase_mgr_pkg::*;
#(
  parameter int NPH     = 8,
  parameter int IW      = 9,
  parameter int DET_CYC = 150000,
  parameter int DWELL   = 1000,
  parameter int TH_DCM  = 5,
  parameter int TH_ONE  = 15,
  parameter int TH_TWO  = 25,
  parameter int HYS     = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPH-1:0]             sense_hi_i,
  input  logic                       auto_en_i,
  input  logic [1:0]                 pstate_i,
  input  logic [IW-1:0]              load_i,
  output logic                       det_done_o,
  output logic [$clog2(NPH+1)-1:0]   pop_cnt_o,
  output logic [NPH-1:0]             en_mask_o,
  output logic                       dcm_o
);
  localparam int CW = $clog2(NPH + 1);

  lvl_e lvl;

  phase_detect #(.NPH(NPH), .DET_CYC(DET_CYC), .CW(CW)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sense_hi_i (sense_hi_i),
    .done_o     (det_done_o),
    .pop_o      (pop_cnt_o)
  );

  load_level #(
    .IW(IW), .TH_DCM(TH_DCM), .TH_ONE(TH_ONE), .TH_TWO(TH_TWO),
    .HYS(HYS), .DWELL(DWELL)
  ) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .lvl_o  (lvl)
  );

  phase_mask_dec #(.NPH(NPH), .CW(CW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (det_done_o),
    .pop_i     (pop_cnt_o),
    .lvl_i     (lvl),
    .pstate_i  (pstate_i),
    .auto_en_i (auto_en_i),
    .mask_o    (en_mask_o),
    .dcm_o     (dcm_o)
  );

  assert_idle_in_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_done_o |-> (en_mask_o == '0 && !dcm_o));
endmodule

// File: tb/tb_phase_mgr.sv
module tb_phase_mgr;
  localparam int NPH = 4, IW = 7, DET = 20, DWELL = 8, HYS = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NPH-1:0] sense_hi_i = '0;
  logic auto_en_i = 1'b0;
  logic [1:0] pstate_i = 2'd0;
  logic [IW-1:0] load_i = '0;
  logic det_done_o, dcm_o;
  logic [2:0] pop_cnt_o;
  logic [NPH-1:0] en_mask_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_lvl, m_cnt;

  always #5 clk_i = ~clk_i;

  phase_mgr #(.NPH(NPH), .IW(IW), .DET_CYC(DET), .DWELL(DWELL), .HYS(HYS)) dut (
    .clk_i, .rst_ni, .sense_hi_i, .auto_en_i, .pstate_i, .load_i,
    .det_done_o, .pop_cnt_o, .en_mask_o, .dcm_o
  );

  function automatic int up_of(int l);
    return (l >= 25) ? 3 : (l >= 15) ? 2 : (l >= 5) ? 1 : 0;
  endfunction
  function automatic int dn_of(int l);
    return (l >= 25 - HYS) ? 3 : (l >= 15 - HYS) ? 2 : (l >= 5 - HYS) ? 1 : 0;
  endfunction

  // arithmetic level model (R4 R5 R6)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lvl <= 3; m_cnt <= 0;
    end else if (up_of(int'(load_i)) > m_lvl) begin
      m_lvl <= up_of(int'(load_i)); m_cnt <= 0;
    end else if (dn_of(int'(load_i)) < m_lvl) begin
      if (m_cnt == DWELL - 1) begin m_lvl <= dn_of(int'(load_i)); m_cnt <= 0; end
      else m_cnt <= m_cnt + 1;
    end else m_cnt <= 0;
  end

  function automatic int exp_pop(logic [NPH-1:0] s);
    int p = 1;
    for (int k = 1; k < NPH; k++) begin
      if (s[k]) break;
      p++;
    end
    return p;
  endfunction
  function automatic int exp_n(int ps, bit au, int lv, int pop);
    if (ps != 0) return 1;
    if (!au) return pop;
    if (lv <= 1) return 1;
    if (lv == 2) return (pop < 2) ? pop : 2;
    return pop;
  endfunction
  function automatic bit exp_dcm(int ps, bit au, int lv);
    return (lv == 0) && ((ps == 0 && au) || ps >= 2);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic start(logic [NPH-1:0] s);
    rst_ni = 1'b0; sense_hi_i = s;
    repeat (2) @(negedge clk_i);
    check("R1 reset done", int'(det_done_o), 0);
    check("R1 reset mask", int'(en_mask_o), 0);
    rst_ni = 1'b1;
    repeat (DET - 1) @(negedge clk_i);
    check("R1 window still open", int'(det_done_o), 0);
    check("R1 mask idle in window", int'(en_mask_o), 0);
    check("R1 dcm idle in window", int'(dcm_o), 0);
    @(negedge clk_i);
    check("R1 window closed", int'(det_done_o), 1);
  endtask

  task automatic cmp_cycle(int pop);
    string req;
    int n;
    req = (pstate_i == 0 && !auto_en_i) ? "R3" : (pstate_i == 0) ? "R4 R5 R6 R9" :
          (pstate_i == 1) ? "R7" : "R8";
    n = exp_n(int'(pstate_i), auto_en_i, m_lvl, pop);
    check({req, " mask"}, int'(en_mask_o), (1 << n) - 1);
    check({req, " dcm"}, int'(dcm_o), int'(exp_dcm(int'(pstate_i), auto_en_i, m_lvl)));
  endtask

  task automatic run_load(int v, int hold, int pop);
    for (int h = 0; h < hold; h++) begin
      load_i = IW'(v);
      @(negedge clk_i);
      cmp_cycle(pop);
    end
  endtask

  task automatic script(int pop);
    int lv[18] = '{4, 3, 2, 5, 16, 14, 12, 30, 22, 24, 22, 20, 24, 20, 26, 23, 13, 0};
    int hd[18] = '{12, 10, 10, 3, 3, 10, 12, 2, 5, 3, 12, 5, 1, 12, 2, 12, 12, 12};
    for (int v = 0; v <= 40; v++) run_load(v, 1, pop);
    for (int v = 40; v >= 0; v--) run_load(v, 1, pop);
    for (int i = 0; i < 18; i++) run_load(lv[i], hd[i], pop);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 R3: every sense pattern, PS0 strap off
    pstate_i = 2'd0; auto_en_i = 1'b0; load_i = '0;
    for (int s = 0; s < (1 << NPH); s++) begin
      start(NPH'(s));
      check("R2 pop count", int'(pop_cnt_o), exp_pop(NPH'(s)));
      check("R3 all populated", int'(en_mask_o), (1 << exp_pop(NPH'(s))) - 1);
    end

    // R2: one-cycle pulse inside the window still marks phase 3 unpopulated
    rst_ni = 1'b0; sense_hi_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (9) @(negedge clk_i);
    sense_hi_i = 4'b0100;
    @(negedge clk_i);
    sense_hi_i = '0;
    repeat (DET - 10) @(negedge clk_i);
    check("R2 glitch sticky done", int'(det_done_o), 1);
    check("R2 glitch sticky pop", int'(pop_cnt_o), 2);

    // R2: sense after window ignored
    start('0);
    sense_hi_i = 4'b1110;
    repeat (5) @(negedge clk_i);
    check("R2 late sense pop", int'(pop_cnt_o), 4);
    check("R2 late sense mask", int'(en_mask_o), 4'hF);
    sense_hi_i = '0;

    // directed thresholds, PS0 auto, pop 4
    auto_en_i = 1'b1;
    load_i = 7'd30; @(negedge clk_i);
    check("R4 all at 30", int'(en_mask_o), 4'hF);
    load_i = 7'd23; repeat (12) @(negedge clk_i);
    check("R5 hold at 23", int'(en_mask_o), 4'hF);
    load_i = 7'd22; repeat (DWELL - 1) @(negedge clk_i);
    check("R6 before dwell", int'(en_mask_o), 4'hF);
    @(negedge clk_i);
    check("R6 at dwell", int'(en_mask_o), 4'h3);
    load_i = 7'd25; @(negedge clk_i);
    check("R4 rise at 25", int'(en_mask_o), 4'hF);
    load_i = 7'd2; repeat (DWELL) @(negedge clk_i);
    check("R6 direct drop mask", int'(en_mask_o), 4'h1);
    check("R4 dcm below 5", int'(dcm_o), 1);
    load_i = 7'd5; @(negedge clk_i);
    check("R4 ccm at 5", int'(dcm_o), 0);
    load_i = 7'd15; @(negedge clk_i);
    check("R4 two at 15", int'(en_mask_o), 4'h3);
    load_i = 7'd12; repeat (4) @(negedge clk_i);
    load_i = 7'd14; @(negedge clk_i);
    load_i = 7'd12; repeat (DWELL - 1) @(negedge clk_i);
    check("R6 restart after break", int'(en_mask_o), 4'h3);
    @(negedge clk_i);
    check("R6 drop after restart", int'(en_mask_o), 4'h1);

    // sweep every mode over three populated counts against the model
    for (int p = 0; p < 3; p++) begin
      logic [NPH-1:0] sp;
      sp = (p == 0) ? 4'b0000 : (p == 1) ? 4'b0100 : 4'b0010;
      start(sp);
      for (int ps = 0; ps < 4; ps++) begin
        for (int au = 0; au < 2; au++) begin
          pstate_i = 2'(ps); auto_en_i = au[0];
          script(exp_pop(sp));
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule